// File: doc/BRIEF.md
# Serial 24-bit Frame Receiver with Chain Output

This block is the serial front end of a two-channel converter's control port. A host lowers an active-low frame select, clocks bits in on a serial clock and raises frame select to close the frame. The block shifts the data into a 24-bit register, most significant bit first, one bit per falling clock edge. When the frame closes it checks how many bits arrived. A good frame produces a one-cycle valid strobe together with the 24-bit word. A bad frame produces a one-cycle error strobe instead.

Bits pushed past the top of the register leave on a serial output. This output changes after a rising serial clock edge, so a second device fed from it samples a settled bit on the next falling edge. A static mode input picks the length rule. Standalone mode wants exactly 24 bits. Chained mode accepts any nonzero multiple of 24 and keeps the last 24 bits. All three serial inputs are resynchronised into the system clock domain, so the serial clock must run at no more than a quarter of the system clock rate. It may be a gated burst or a free-running clock, because nothing is shifted while frame select is high.

The word output has no ready input and cannot apply back-pressure. The word is offered once, on the valid strobe, and the consumer must take it in that cycle. A new frame can start only after frame select goes high and then low again.

Top module: `spi_frame_rx`

## Requirements
- R1: Out of reset, `frm_valid`, `frm_err`, `sdo` and `frm_data` are all 0.
- R2: A falling edge of `cs_n` opens a frame and clears the bit count and the shift register. While the frame is open, each falling `sclk` edge shifts in `sdi`. The first bit of a 24-bit frame ends up in `frm_data[23]`.
- R3: With `chain_mode`=0, a frame of exactly 24 falling `sclk` edges is closed by `cs_n` rising. This gives one `frm_valid` pulse carrying the 24 bits.
- R4: With `chain_mode`=0, a frame with fewer than 24 falling edges gives one `frm_err` pulse and no `frm_valid`. This includes a frame with no edges at all.
- R5: With `chain_mode`=0, a frame with more than 24 falling edges gives one `frm_err` pulse and no `frm_valid`.
- R6: With `chain_mode`=1, a frame whose edge count is a nonzero multiple of 24 gives one `frm_valid` pulse carrying the last 24 bits received. Any other count, including zero, gives one `frm_err` pulse.
- R7: `sdo` is cleared when a frame opens and is updated only after rising `sclk` edges of an open frame. Just before falling edge k of a frame (counting from 0), `sdo` equals the bit sampled at falling edge k-24, or 0 when k is below 24.
- R8: While `cs_n` is high, activity on `sclk` and `sdi` changes nothing. `sdo` holds, no strobe appears, and the next frame decodes normally.
- R9: `frm_valid` and `frm_err` each last exactly one cycle and are never high together. Each frame close gives exactly one of them, and neither appears at any other time.
- R10: `frm_data` changes only together with a `frm_valid` pulse. It holds its value through error frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_mode | input | 1 | Static length rule: 0 exact 24, 1 nonzero multiple of 24 |
| sclk | input | 1 | Serial clock, idle high, asynchronous to `clk` |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, sampled on falling `sclk` |
| sdo | output | 1 | Serial chain output, updated after rising `sclk` |
| frm_valid | output | 1 | One-cycle strobe for a frame of correct length |
| frm_err | output | 1 | One-cycle strobe for a frame of wrong length |
| frm_data | output | 24 | Received word, new with each `frm_valid` |

## Verification
Some rules are checked on every cycle. Both strobes are single-cycle and mutually exclusive. Every frame close yields exactly one strobe, and no strobe appears without a close. `sdo` moves only in the cycle after a detected rising serial clock edge or a frame opening. Other properties can only be shown by the bench's scenarios. These are that the word carries the right bits in the right order, and that the length rules of each mode sort counts of 0, 23, 24, 25, 47 and 48 correctly. They also include the exact bit delay from `sdi` to `sdo`, and that idle clocking leaves no trace.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  // Length summary of a closed frame, produced by the shifter.
  typedef struct packed {
    logic full;     // at least one whole word received
    logic extra;    // edges arrived after the first whole word
    logic aligned;  // count is a whole number of words
  } len_stat_t;

  // Length rule selected by the static mode input.
  function automatic logic len_ok(input len_stat_t s, input logic chained);
    if (chained) return s.full && s.aligned;
    return s.full && s.aligned && !s.extra;
  endfunction

endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rx_edge.sv
module spi_rx_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter
  import spi_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_evt,
  input  logic              close_evt,
  input  logic              bit_fall,
  input  logic              bit_rise,
  input  logic              bit_in,
  output logic              in_frame,
  output logic [WORD_W-1:0] word,
  output len_stat_t         stat,
  output logic              chain_out
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  pos;
  logic              full_q, extra_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      pos       <= '0;
      full_q    <= 1'b0;
      extra_q   <= 1'b0;
      in_frame  <= 1'b0;
      chain_out <= 1'b0;
    end else if (open_evt) begin
      shreg     <= '0;
      pos       <= '0;
      full_q    <= 1'b0;
      extra_q   <= 1'b0;
      in_frame  <= 1'b1;
      chain_out <= 1'b0;
    end else if (in_frame) begin
      if (close_evt) begin
        in_frame <= 1'b0;
      end else begin
        if (bit_fall) begin
          shreg <= {shreg[WORD_W-2:0], bit_in};
          if (full_q) extra_q <= 1'b1;
          if (pos == LAST) begin
            pos    <= '0;
            full_q <= 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        // Overflowing bit leaves after the rising edge, ready for the next fall.
        if (bit_rise) chain_out <= shreg[WORD_W-1];
      end
    end
  end

  assign word         = shreg;
  assign stat.full    = full_q;
  assign stat.extra   = extra_q;
  assign stat.aligned = (pos == '0);
endmodule

// File: rtl/spi_rx_judge.sv
module spi_rx_judge
  import spi_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chained,
  input  logic              close_evt,
  input  len_stat_t         stat,
  input  logic [WORD_W-1:0] word,
  output logic              good,
  output logic              bad,
  output logic [WORD_W-1:0] data
);
  logic pass;
  assign pass = len_ok(stat, chained);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good <= 1'b0;
      bad  <= 1'b0;
      data <= '0;
    end else begin
      good <= close_evt & pass;
      bad  <= close_evt & ~pass;
      if (close_evt && pass) data <= word;
    end
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_rx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_mode,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              frm_valid,
  output logic              frm_err,
  output logic [WORD_W-1:0] frm_data
);
  // Synchronised bundle: {frame select, serial clock, serial data}.
  logic [2:0] pins_s;
  logic       cs_rise_w, cs_fall_w, sclk_rise_w, sclk_fall_w;
  logic       open_w, close_w;
  logic [WORD_W-1:0] word_w;
  len_stat_t  stat_w;

  spi_rx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  spi_rx_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_s[2]), .rise(cs_rise_w), .fall(cs_fall_w)
  );

  spi_rx_edge #(.RST_VAL(1'b1)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_s[1]), .rise(sclk_rise_w), .fall(sclk_fall_w)
  );

  assign close_w = cs_rise_w & open_w;

  spi_rx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .open_evt(cs_fall_w), .close_evt(close_w),
    .bit_fall(sclk_fall_w), .bit_rise(sclk_rise_w), .bit_in(pins_s[0]),
    .in_frame(open_w), .word(word_w), .stat(stat_w), .chain_out(sdo)
  );

  spi_rx_judge #(.WORD_W(WORD_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .chained(chain_mode), .close_evt(close_w),
    .stat(stat_w), .word(word_w),
    .good(frm_valid), .bad(frm_err), .data(frm_data)
  );
endmodule

// File: rtl/spi_frame_rx_chk.sv
module spi_frame_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic close_w,
  input logic sclk_rise_w,
  input logic cs_fall_w,
  input logic frm_valid,
  input logic frm_err,
  input logic sdo
);
  // R9: valid lasts one cycle
  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);

  // R9: error lasts one cycle
  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |=> !frm_err);

  // R9: never both strobes
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_valid && frm_err));

  // R9: a close always yields exactly one strobe
  p_close_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    close_w |=> (frm_valid ^ frm_err));

  // R9: no strobe without a close
  p_strobe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid || frm_err) |-> $past(close_w));

  // R7 / R8: sdo moves only after a rising serial edge or a frame opening
  p_sdo_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise_w && !cs_fall_w) |=> $stable(sdo));
endmodule

bind spi_frame_rx spi_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .close_w(close_w), .sclk_rise_w(sclk_rise_w),
  .cs_fall_w(cs_fall_w), .frm_valid(frm_valid), .frm_err(frm_err), .sdo(sdo)
);

// File: tb/spi_frame_rx_test.sv
module spi_frame_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;  // system clocks per serial half period

  logic clk = 1'b0, rst_n = 1'b0;
  logic chain_mode = 1'b0, sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, frm_valid, frm_err;
  logic [23:0] frm_data;

  int tests = 0, fails = 0;
  int n_valid = 0, n_err = 0, n_both = 0, n_double = 0;
  logic prev_v = 1'b0, prev_e = 1'b0;
  logic [23:0] last_data = '0;
  bit done = 1'b0;

  spi_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .sclk(sclk), .cs_n(cs_n),
    .sdi(sdi), .sdo(sdo), .frm_valid(frm_valid), .frm_err(frm_err), .frm_data(frm_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Strobe monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (frm_valid) begin n_valid++; last_data = frm_data; end
      if (frm_err) n_err++;
      if (frm_valid && frm_err) n_both++;
      if ((frm_valid && prev_v) || (frm_err && prev_e)) n_double++;
      prev_v = frm_valid;
      prev_e = frm_err;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_ok(input int n, input bit chained);
    if (chained) return (n > 0) && (n % 24 == 0);
    return n == 24;
  endfunction

  // Sends n bits, first st[n-1] down to st[0]; checks sdo before each fall (R7).
  task automatic send_frame(input int n, input logic [71:0] st);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < n; k++) begin
      logic e;
      e = (k < 24) ? 1'b0 : st[n-1-(k-24)];
      check(sdo === e, "R7 sdo", longint'(sdo), longint'(e));
      sdi = st[n-1-k];
      wait_clk(2);
      sclk = 1'b0;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic run_frame(input int n, input logic [71:0] st, input string req);
    int v0, e0;
    logic [23:0] d0;
    bit ok;
    v0 = n_valid; e0 = n_err; d0 = last_data;
    ok = exp_ok(n, chain_mode);
    send_frame(n, st);
    check(n_valid - v0 == (ok ? 1 : 0), req, n_valid - v0, ok ? 1 : 0);
    check(n_err - e0 == (ok ? 0 : 1), req, n_err - e0, ok ? 0 : 1);
    if (ok) check(last_data == st[23:0], req, last_data, st[23:0]);
    else    check(frm_data == d0, "R10 data held", frm_data, d0);
  endtask

  function automatic logic [71:0] rnd72();
    return {8'($urandom), 32'($urandom), 32'($urandom)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    wait_clk(1);
    // R1: reset values
    check(frm_valid == 0 && frm_err == 0, "R1 strobes", {frm_valid, frm_err}, 0);
    check(sdo == 0, "R1 sdo", sdo, 0);
    check(frm_data == 0, "R1 data", frm_data, 0);
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);

    // R2, R3: exact word, MSB first
    chain_mode = 1'b0;
    run_frame(24, 72'h0000_0000_0000_A5C3_81, "R3 exact 24");
    check(frm_data == 24'hA5C381, "R2 bit order", frm_data, 24'hA5C381);
    run_frame(23, rnd72(), "R4 short 23");
    run_frame(0, rnd72(), "R4 empty");
    run_frame(25, rnd72(), "R5 long 25");
    run_frame(48, rnd72(), "R5 long 48");
    run_frame(24, 72'h00_0000_0000_FFFF_FE, "R3 second frame");

    // R6, R7: chained rule and bit ripple
    chain_mode = 1'b1;
    run_frame(48, 72'h00_1234_5678_9ABC_DE, "R6 chain 48");
    run_frame(24, rnd72(), "R6 chain 24");
    run_frame(47, rnd72(), "R6 chain 47");
    run_frame(72, rnd72(), "R6 chain 72");
    run_frame(0, rnd72(), "R6 chain empty");

    // R8: idle clocking with frame select high
    begin
      logic s0;
      int v0, e0;
      s0 = sdo; v0 = n_valid; e0 = n_err;
      for (int i = 0; i < 12; i++) begin
        sdi = 1'($urandom);
        wait_clk(2);
        sclk = 1'b0; wait_clk(HALF);
        sclk = 1'b1; wait_clk(HALF);
      end
      wait_clk(6);
      check(sdo == s0, "R8 sdo held", sdo, s0);
      check(n_valid == v0 && n_err == e0, "R8 no strobe", n_valid + n_err, v0 + e0);
      chain_mode = 1'b0;
      run_frame(24, rnd72(), "R8 frame after idle");
    end

    // Random mix of modes and lengths
    for (int t = 0; t < 40; t++) begin
      int n;
      int pick;
      chain_mode = 1'($urandom);
      pick = int'($urandom_range(0, 3));
      case (pick)
        0: n = 24;
        1: n = chain_mode ? 48 : 25;
        2: n = 23;
        default: n = int'($urandom_range(0, 72));
      endcase
      run_frame(n, rnd72(), chain_mode ? "R6 random" : "R3/R4/R5 random");
    end

    // R9: strobe shape over the whole run
    check(n_both == 0, "R9 exclusive", n_both, 0);
    check(n_double == 0, "R9 single cycle", n_double, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule